// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block sits beside a small 8-bit processor core and decides when the core must break off its program to run a handler. There are five request sources: two external events, two timer overflows, and one serial source. The serial source is raised whenever either the receive flag or the transmit flag of the serial port is set. Software programs an enable register and a priority register. At each instruction boundary reported by the core, the controller picks at most one winning request. It chooses by priority level first and then by a fixed polling order. It keeps track of which priority levels have a handler in progress, so that nesting follows the two-level rules.

When a request is accepted, the controller raises a one-cycle take pulse together with the 16-bit handler address. On the same cycle and the next one it emits two byte-wide stack write strobes that save the return address, low byte first. Flags owned by the controller (external and timer) are cleared by hardware at acceptance. The serial flags belong to the serial port and are never touched. A return-from-interrupt pulse from the core releases the highest level that is in service. The push strobes are plain control outputs with no back-pressure: the core must take a byte on every cycle in which a strobe is high.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the enable register, the priority register, the four hardware-owned flags and both in-service levels read as zero, and no take pulse is produced.
- R2: The enable register uses bit 7 as the global enable, and bits 0..4 for external 0, timer 0, external 1, timer 1 and serial. Bits 6 and 5 always read 0. A source is accepted only when its own bit and bit 7 are both set.
- R3: The priority register uses bits 0..4 in the same source order as the enable register, and a set bit means high priority. Bits 7..5 always read 0.
- R4: Among eligible requests of the same level, the winner is chosen in the order external 0, timer 0, external 1, timer 1, serial.
- R5: An eligible high-priority request wins over every low-priority request, whatever their polling positions.
- R6: While a high-level handler is in service nothing is accepted. A high request may be accepted while only a low-level handler is in service. A low request is accepted only when no level is in service.
- R7: An acceptance happens only on a cycle with `insn_boundary` high. The cycle after it, `take` is high for exactly one cycle and `vector` carries 0003h, 000Bh, 0013h, 001Bh or 0023h for external 0, timer 0, external 1, timer 1 or serial.
- R8: The return address on `pc_in` at the accepting boundary is written out with `push_lo_we` and its low byte on the take cycle, then with `push_hi_we` and its high byte on the following cycle.
- R9: Accepting an external or timer request clears that source's flag (`hw_flags` bit 0 ext0, 1 tmr0, 2 ext1, 3 tmr1) and leaves the other flags unchanged.
- R10: The serial request is the OR of `ser_rx_flag` and `ser_tx_flag`. Accepting it clears neither flag, so it is taken again after a return if still set.
- R11: A `reti` pulse clears the high in-service level if it is set, and otherwise the low level. A boundary in the same cycle as `reti` is not arbitrated.
- R12: Boundaries that fall on the take cycle or the high-byte push cycle are ignored, so no new take can appear until the push pair has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en_we | input | 1 | Write strobe for the enable register |
| cfg_pri_we | input | 1 | Write strobe for the priority register |
| cfg_wdata | input | 8 | Register write data |
| cfg_en_q | output | 8 | Enable register contents |
| cfg_pri_q | output | 8 | Priority register contents |
| ext_evt | input | 2 | External event set pulses (bit 0 ext0, bit 1 ext1) |
| tmr_ovf | input | 2 | Timer overflow set pulses (bit 0 tmr0, bit 1 tmr1) |
| ser_rx_flag | input | 1 | Serial receive flag level |
| ser_tx_flag | input | 1 | Serial transmit flag level |
| hw_flags | output | 4 | Hardware-owned pending flags |
| insn_boundary | input | 1 | One-cycle instruction-boundary strobe from the core |
| reti | input | 1 | One-cycle return-from-interrupt pulse |
| pc_in | input | 16 | Return address to save on entry |
| take | output | 1 | One-cycle interrupt-entry pulse |
| vector | output | 16 | Handler address, valid with take |
| push_lo_we | output | 1 | Stack write strobe for the low return byte |
| push_hi_we | output | 1 | Stack write strobe for the high return byte |
| push_data | output | 8 | Return-address byte being pushed |
| isr_hi | output | 1 | A high-level handler is in service |
| isr_lo | output | 1 | A low-level handler is in service |

## Verification
The arbitration is driven with every source pending at once and then with the leading sources removed one by one. This shows that the polling order is followed. Mixing high-priority bits with full request sets separates level-first selection from plain order. Cases with the global enable or an individual enable cleared show that gating comes before arbitration. Directed sequences nest a high handler over a low one and return through both levels with a boundary landing on the `reti` cycle and on the push cycles. A serial request driven by the transmit flag alone is taken twice across a return, which tells hardware clearing apart from software-owned flags.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC    = 5;
  localparam int NHW     = 4;
  localparam int REG_W   = 8;
  localparam int ADDR_W  = 16;
  localparam int EA_BIT  = 7;
  localparam int VEC_BASE = 3;
  localparam int VEC_STEP = 8;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LO   = 2'd1,
    SEQ_HI   = 2'd2
  } seq_t;

  function automatic logic [ADDR_W-1:0] vec_of(input int idx);
    return ADDR_W'(VEC_BASE + VEC_STEP * idx);
  endfunction
endpackage

// File: rtl/irq_src_flags.sv
module irq_src_flags #(
  parameter int NHW = irq_pkg::NHW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NHW-1:0] set_i,
  input  logic [NHW-1:0] clr_i,
  input  logic           ser_rx,
  input  logic           ser_tx,
  output logic [NHW-1:0] flags_o,
  output logic [NHW:0]   req_o
);
  logic [NHW-1:0] flag_q;

  generate
    for (genvar g = 0; g < NHW; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag_q[g] <= 1'b0;
        else if (set_i[g]) flag_q[g] <= 1'b1;
        else if (clr_i[g]) flag_q[g] <= 1'b0;
      end

      assert_hw_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[g] && !set_i[g]) |=> !flag_q[g]);
    end
  endgenerate

  assign flags_o = flag_q;
  assign req_o   = {ser_rx | ser_tx, flag_q};
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC = irq_pkg::NSRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] en,
  input  logic            ea,
  input  logic [NSRC-1:0] pri,
  input  logic            isr_hi,
  input  logic            isr_lo,
  output logic [NSRC-1:0] grant,
  output logic            grant_hi
);
  logic [NSRC-1:0] elig, hi_c, lo_c, pick;
  logic allow_hi, allow_lo, found;

  always_comb begin
    elig     = req & en & {NSRC{ea}};
    hi_c     = elig & pri;
    lo_c     = elig & ~pri;
    allow_hi = go && !isr_hi;
    allow_lo = go && !isr_hi && !isr_lo;
    grant_hi = allow_hi && (|hi_c);
    if (grant_hi)      pick = hi_c;
    else if (allow_lo) pick = lo_c;
    else               pick = '0;
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (pick[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  assert_one_winner_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_hi_blocks_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    isr_hi |-> (grant == '0));

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_chk
      assert_gate_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        grant[g] |-> (en[g] && ea && req[g]));
      assert_level_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[g] && !pri[g]) |-> ((req & en & pri) == '0 || !ea));
    end
  endgenerate
endmodule

// File: rtl/irq_level_track.sv
module irq_level_track (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic accept_hi,
  input  logic reti,
  output logic isr_hi,
  output logic isr_lo
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_hi <= 1'b0;
      isr_lo <= 1'b0;
    end else if (reti) begin
      if (isr_hi) isr_hi <= 1'b0;
      else        isr_lo <= 1'b0;
    end else if (accept) begin
      if (accept_hi) isr_hi <= 1'b1;
      else           isr_lo <= 1'b1;
    end
  end

  assert_no_accept_on_reti_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reti |-> !accept);

  assert_reti_pops_hi_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && isr_hi) |=> (!isr_hi && isr_lo == $past(isr_lo)));

  assert_low_needs_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !accept_hi) |-> (!isr_hi && !isr_lo));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int NSRC   = irq_pkg::NSRC,
  parameter int ADDR_W = irq_pkg::ADDR_W,
  localparam int IDXW  = $clog2(NSRC),
  localparam int BYTE_W = ADDR_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [IDXW-1:0]   idx,
  input  logic [ADDR_W-1:0] pc_in,
  output logic              busy,
  output logic              take,
  output logic [ADDR_W-1:0] vector,
  output logic              push_lo_we,
  output logic              push_hi_we,
  output logic [BYTE_W-1:0] push_data
);
  import irq_pkg::*;

  seq_t              st_q;
  logic [ADDR_W-1:0] pc_q, vec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      pc_q  <= '0;
      vec_q <= '0;
    end else begin
      unique case (st_q)
        SEQ_IDLE: if (accept) begin
          st_q  <= SEQ_LO;
          pc_q  <= pc_in;
          vec_q <= vec_of(int'(idx));
        end
        SEQ_LO:  st_q <= SEQ_HI;
        SEQ_HI:  st_q <= SEQ_IDLE;
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy       = (st_q != SEQ_IDLE);
  assign take       = (st_q == SEQ_LO);
  assign push_lo_we = (st_q == SEQ_LO);
  assign push_hi_we = (st_q == SEQ_HI);
  assign vector     = vec_q;
  assign push_data  = (st_q == SEQ_HI) ? pc_q[ADDR_W-1:BYTE_W] : pc_q[BYTE_W-1:0];

  assert_push_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push_lo_we |=> (push_hi_we && !push_lo_we && $stable(push_data) == 1'b0 || push_hi_we));

  assert_hi_after_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push_hi_we |-> $past(push_lo_we));

  assert_no_arb_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !busy);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NSRC   = irq_pkg::NSRC,
  parameter int NHW    = irq_pkg::NHW,
  parameter int REG_W  = irq_pkg::REG_W,
  parameter int ADDR_W = irq_pkg::ADDR_W,
  localparam int IDXW  = $clog2(NSRC),
  localparam int BYTE_W = ADDR_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en_we,
  input  logic              cfg_pri_we,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_en_q,
  output logic [REG_W-1:0]  cfg_pri_q,
  input  logic [1:0]        ext_evt,
  input  logic [1:0]        tmr_ovf,
  input  logic              ser_rx_flag,
  input  logic              ser_tx_flag,
  output logic [NHW-1:0]    hw_flags,
  input  logic              insn_boundary,
  input  logic              reti,
  input  logic [ADDR_W-1:0] pc_in,
  output logic              take,
  output logic [ADDR_W-1:0] vector,
  output logic              push_lo_we,
  output logic              push_hi_we,
  output logic [BYTE_W-1:0] push_data,
  output logic              isr_hi,
  output logic              isr_lo
);
  import irq_pkg::*;

  localparam logic [REG_W-1:0] SRC_MASK = REG_W'((1 << NSRC) - 1);
  localparam logic [REG_W-1:0] EN_MASK  = SRC_MASK | (REG_W'(1) << EA_BIT);

  logic [REG_W-1:0] en_q, pri_q;
  logic [NHW-1:0]   set_v, clr_v;
  logic [NSRC-1:0]  req_v, grant;
  logic             grant_hi, accept, busy, go;
  logic [IDXW-1:0]  win_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      pri_q <= '0;
    end else begin
      if (cfg_en_we)  en_q  <= cfg_wdata & EN_MASK;
      if (cfg_pri_we) pri_q <= cfg_wdata & SRC_MASK;
    end
  end

  assign cfg_en_q  = en_q;
  assign cfg_pri_q = pri_q;

  // Polling index order: ext0, tmr0, ext1, tmr1
  assign set_v = {tmr_ovf[1], ext_evt[1], tmr_ovf[0], ext_evt[0]};
  assign clr_v = accept ? grant[NHW-1:0] : '0;

  irq_src_flags #(.NHW(NHW)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (set_v),
    .clr_i   (clr_v),
    .ser_rx  (ser_rx_flag),
    .ser_tx  (ser_tx_flag),
    .flags_o (hw_flags),
    .req_o   (req_v)
  );

  assign go = insn_boundary && !busy && !reti;

  irq_arbiter #(.NSRC(NSRC)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .req      (req_v),
    .en       (en_q[NSRC-1:0]),
    .ea       (en_q[EA_BIT]),
    .pri      (pri_q[NSRC-1:0]),
    .isr_hi   (isr_hi),
    .isr_lo   (isr_lo),
    .grant    (grant),
    .grant_hi (grant_hi)
  );

  assign accept = |grant;

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (grant[i]) win_idx = IDXW'(i);
    end
  end

  irq_level_track u_lvl (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .accept_hi (grant_hi),
    .reti      (reti),
    .isr_hi    (isr_hi),
    .isr_lo    (isr_lo)
  );

  irq_entry_seq #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .idx        (win_idx),
    .pc_in      (pc_in),
    .busy       (busy),
    .take       (take),
    .vector     (vector),
    .push_lo_we (push_lo_we),
    .push_hi_we (push_hi_we),
    .push_data  (push_data)
  );

  assert_take_on_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take) |-> $past(insn_boundary));

  assert_take_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);

  assert_unused_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en_q[6:5] == 2'b00) && (cfg_pri_q[REG_W-1:NSRC] == '0));

  assert_take_sets_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (isr_hi || isr_lo));
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en_we = 0, cfg_pri_we = 0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_en_q, cfg_pri_q;
  logic [1:0]  ext_evt = '0, tmr_ovf = '0;
  logic        ser_rx_flag = 0, ser_tx_flag = 0;
  logic [3:0]  hw_flags;
  logic        insn_boundary = 0, reti = 0;
  logic [15:0] pc_in = '0;
  logic        take, push_lo_we, push_hi_we, isr_hi, isr_lo;
  logic [15:0] vector;
  logic [7:0]  push_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_en_we(cfg_en_we), .cfg_pri_we(cfg_pri_we),
    .cfg_wdata(cfg_wdata), .cfg_en_q(cfg_en_q), .cfg_pri_q(cfg_pri_q),
    .ext_evt(ext_evt), .tmr_ovf(tmr_ovf), .ser_rx_flag(ser_rx_flag),
    .ser_tx_flag(ser_tx_flag), .hw_flags(hw_flags), .insn_boundary(insn_boundary),
    .reti(reti), .pc_in(pc_in), .take(take), .vector(vector),
    .push_lo_we(push_lo_we), .push_hi_we(push_hi_we), .push_data(push_data),
    .isr_hi(isr_hi), .isr_lo(isr_lo)
  );

  // {enable, priority, requests(bit4 serial .. bit0 ext0), expect take, expected source}
  localparam int NV = 12;
  localparam logic [24:0] TBL [NV] = '{
    {8'h9F, 8'h00, 5'b11111, 1'b1, 3'd0},
    {8'h9F, 8'h00, 5'b11110, 1'b1, 3'd1},
    {8'h9F, 8'h00, 5'b11100, 1'b1, 3'd2},
    {8'h9F, 8'h00, 5'b11000, 1'b1, 3'd3},
    {8'h9F, 8'h00, 5'b10000, 1'b1, 3'd4},
    {8'h9F, 8'h10, 5'b11111, 1'b1, 3'd4},
    {8'h9F, 8'h0C, 5'b11111, 1'b1, 3'd2},
    {8'h9F, 8'h08, 5'b01011, 1'b1, 3'd3},
    {8'h1F, 8'h00, 5'b11111, 1'b0, 3'd0},
    {8'h9D, 8'h00, 5'b00010, 1'b0, 3'd0},
    {8'h9D, 8'h02, 5'b00110, 1'b1, 3'd2},
    {8'h88, 8'h00, 5'b01111, 1'b1, 3'd3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    insn_boundary = 0; reti = 0; ext_evt = '0; tmr_ovf = '0;
    ser_rx_flag = 0; ser_tx_flag = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic write_cfg(input logic [7:0] en, input logic [7:0] pri);
    cfg_en_we = 1; cfg_wdata = en;
    @(negedge clk);
    cfg_en_we = 0; cfg_pri_we = 1; cfg_wdata = pri;
    @(negedge clk);
    cfg_pri_we = 0;
  endtask

  task automatic raise(input logic [3:0] hw);
    ext_evt = {hw[2], hw[0]};
    tmr_ovf = {hw[3], hw[1]};
    @(negedge clk);
    ext_evt = '0; tmr_ovf = '0;
  endtask

  // boundary on one cycle; returns in the take cycle
  task automatic boundary(input logic [15:0] pc);
    insn_boundary = 1; pc_in = pc;
    @(negedge clk);
    insn_boundary = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 enable", cfg_en_q, 8'h00);
    chk("R1 priority", cfg_pri_q, 8'h00);
    chk("R1 flags", hw_flags, 4'h0);
    chk("R1 levels", {isr_hi, isr_lo}, 2'b00);
    chk("R1 take", take, 1'b0);

    // R2 R3 unused bits
    write_cfg(8'hFF, 8'hFF);
    chk("R2 unused enable bits", cfg_en_q, 8'h9F);
    chk("R3 unused priority bits", cfg_pri_q, 8'h1F);

    // Table walk: R4 R5 R2 R7
    for (int k = 0; k < NV; k++) begin
      logic [24:0] e;
      e = TBL[k];
      do_reset();
      write_cfg(e[24:17], e[16:9]);
      raise(e[7:4]);
      ser_rx_flag = e[8];
      boundary(16'h0100 + 16'(k));
      chk($sformatf("R4/R5/R2 vec%0d take", k), take, e[3]);
      if (e[3]) chk($sformatf("R7 vec%0d vector", k), vector, 16'(3 + 8 * int'(e[2:0])));
      @(negedge clk);
      ser_rx_flag = 0;
    end

    // R8 push bytes, R9 flag clearing
    do_reset();
    write_cfg(8'h9F, 8'h00);
    raise(4'b0011);
    boundary(16'hA55A);
    chk("R8 lo strobe", {take, push_lo_we, push_hi_we}, 3'b110);
    chk("R8 lo byte", push_data, 8'h5A);
    chk("R9 ext0 cleared, tmr0 kept", hw_flags, 4'b0010);
    @(negedge clk);
    chk("R8 hi strobe", {take, push_lo_we, push_hi_we}, 3'b001);
    chk("R8 hi byte", push_data, 8'hA5);
    @(negedge clk);
    chk("R8 strobes idle", {push_lo_we, push_hi_we}, 2'b00);

    // R12 suppression and R6 nesting
    do_reset();
    write_cfg(8'h9F, 8'h02);
    raise(4'b0001);
    insn_boundary = 1; pc_in = 16'h1234;
    @(negedge clk);
    chk("R7 low take ext0", vector, 16'h0003);
    chk("R6 low level set", {isr_hi, isr_lo}, 2'b01);
    tmr_ovf = 2'b01;
    @(negedge clk);
    tmr_ovf = 2'b00;
    chk("R12 no take on push-high cycle", take, 1'b0);
    @(negedge clk);
    chk("R12 no take after boundary in push", take, 1'b0);
    @(negedge clk);
    insn_boundary = 0;
    chk("R6 high preempts low take", take, 1'b1);
    chk("R6 high preempts vector", vector, 16'h000B);
    chk("R6 both levels", {isr_hi, isr_lo}, 2'b11);
    chk("R9 tmr0 cleared", hw_flags, 4'b0000);
    @(negedge clk);
    raise(4'b0100);
    boundary(16'h2000);
    chk("R6 nothing during high", take, 1'b0);
    insn_boundary = 1; reti = 1;
    @(negedge clk);
    insn_boundary = 0; reti = 0;
    chk("R11 reti clears high", {isr_hi, isr_lo}, 2'b01);
    chk("R11 boundary on reti ignored", take, 1'b0);
    boundary(16'h2000);
    chk("R6 low blocked by low", take, 1'b0);
    reti = 1;
    @(negedge clk);
    reti = 0;
    chk("R11 reti clears low", {isr_hi, isr_lo}, 2'b00);
    boundary(16'h2002);
    chk("R7 ext1 vector", {take, vector}, {1'b1, 16'h0013});
    chk("R9 ext1 cleared", hw_flags, 4'b0000);
    @(negedge clk);

    // R10 serial via transmit flag, not cleared
    do_reset();
    write_cfg(8'h90, 8'h00);
    ser_tx_flag = 1;
    boundary(16'h3000);
    chk("R10 tx take", {take, vector}, {1'b1, 16'h0023});
    @(negedge clk);
    reti = 1;
    @(negedge clk);
    reti = 0;
    boundary(16'h3002);
    chk("R10 retaken, flag not cleared", {take, vector}, {1'b1, 16'h0023});
    @(negedge clk);
    ser_tx_flag = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule